// File: doc/BRIEF.md
# Byte-Sliced Bidirectional Holding Transceiver

This block sits between two 16-bit buses, called A and B, and moves data between them without inverting it. It has two storage banks that are fully separate. One bank holds data travelling from A to B. The other holds data travelling from B to A. Each bank is split into byte lanes. Every lane in every direction has its own three active-low controls:
- an enable, which gates both the storage and the output driver;
- a hold control, which freezes the storage while it is high;
- a drive control, which gates only the output driver.

Two control lanes can be wired together from outside to run the bus as one 16-bit path.

Each bus has a separate input vector and a separate output vector, plus one drive flag per byte. There are no tri-state pins. An outer pad wrapper puts a byte onto the shared wires only while that byte's flag is set.

The storage is synchronous. It loads on each rising clock edge at which its lane is open. While the lane is open, the stored contents are bypassed and the live input is passed straight through. The data path is plain: it has no valid/ready handshake and no back-pressure. Every pin is a level-sampled control or data signal.

Top module: `dual_bank_xcvr`

## Requirements
- R1: Byte k (k = 0 or 1) occupies bits 8k+7 down to 8k of every data vector. It is governed only by bit k of each control vector, so a setting on one byte never changes the other byte's storage, flags or data.
- R2: `b_drive[k]` is 1 exactly when `ab_en_n[k]` and `ab_drv_n[k]` are both 0. `a_drive[k]` is 1 exactly when `ba_en_n[k]` and `ba_drv_n[k]` are both 0. A high enable therefore forces the flag to 0 whatever the other two controls are.
- R3: While a byte's drive flag is 0, that byte of the matching output vector reads all zeros.
- R4: A lane is open when its enable and its hold control are both 0. While a lane is open and driving, its output byte equals the live input byte in the same cycle, bit for bit and without inversion.
- R5: On every rising clock edge at which a lane is open, its storage loads the input byte. After the hold control or the enable goes high, the lane keeps the byte that was present at the last edge at which it was open. Loading takes place whether or not the output is driving.
- R6: While the enable or the hold control is 1, the storage does not change, whatever the input or drive control does. A driving byte shows the stored value.
- R7: The B-to-A direction obeys R2 to R6, using `b_in` and the `ba_*` controls and producing `a_out`. Its storage is independent: loading one direction never alters the other.
- R8: An active-low `rst_n` clears both storage banks to zero at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage loads on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of both storage banks |
| a_in | input | 16 | Data arriving from the A bus |
| b_in | input | 16 | Data arriving from the B bus |
| ab_en_n | input | 2 | A-to-B per-byte enable, active low |
| ab_hold_n | input | 2 | A-to-B per-byte hold control, active low (low = open) |
| ab_drv_n | input | 2 | A-to-B per-byte drive control, active low |
| ba_en_n | input | 2 | B-to-A per-byte enable, active low |
| ba_hold_n | input | 2 | B-to-A per-byte hold control, active low (low = open) |
| ba_drv_n | input | 2 | B-to-A per-byte drive control, active low |
| b_out | output | 16 | Data to place on the B bus |
| b_drive | output | 2 | Per-byte flag: drive `b_out` onto the B bus |
| a_out | output | 16 | Data to place on the A bus |
| a_drive | output | 2 | Per-byte flag: drive `a_out` onto the A bus |

## Verification
The main function is exercised with the following patterns:
- **Both bytes together:** distinct data in every byte is sent through the lanes while they are open, and then held while new data is applied. This separates bypass from stored output.
- **Split settings:** one byte is open while the other is held, and one byte is disabled while the other is transparent. This separates correct per-byte slicing from crosstalk between bytes.
- **Alternating directions:** loading one direction and then reading the other shows whether the banks are truly separate.
- **Loading while not driving:** this shows that the drive control gates only the output and never the storage.

A final sweep sets each direction's enables to the complement of the other direction's. It runs through every combination of drive controls and confirms that no byte is ever flagged in both directions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Storage mode of a single byte lane
  typedef enum logic {
    LANE_HOLD = 1'b0,
    LANE_OPEN = 1'b1
  } lane_mode_e;

  function automatic lane_mode_e lane_mode(input logic en_n, input logic hold_n);
    return (!en_n && !hold_n) ? LANE_OPEN : LANE_HOLD;
  endfunction
endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] d_in,
  input  logic              en_n,
  input  logic              hold_n,
  input  logic              drv_n,
  output logic [LANE_W-1:0] q_out,
  output logic              drive
);
  lane_mode_e        mode;
  logic [LANE_W-1:0] held;
  logic [LANE_W-1:0] view;

  assign mode = lane_mode(en_n, hold_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 held <= '0;
    else if (mode == LANE_OPEN) held <= d_in;
  end

  assign view  = (mode == LANE_OPEN) ? d_in : held;
  assign drive = !en_n && !drv_n;
  assign q_out = drive ? view : '0;

  AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !hold_n) |=> (held == $past(d_in))); // R5
  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n || hold_n) |=> (held == $past(held))); // R6
  AST_EN_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> !drive); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> (q_out == '0)); // R3
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !hold_n && !drv_n) |-> (q_out == d_in)); // R4
  AST_HELD_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && hold_n && !drv_n) |-> (q_out == held)); // R6
endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir #(
  parameter int NUM_BYTES = 2,
  parameter int BYTE_W    = 8,
  localparam int DW       = NUM_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        d_in,
  input  logic [NUM_BYTES-1:0] en_n,
  input  logic [NUM_BYTES-1:0] hold_n,
  input  logic [NUM_BYTES-1:0] drv_n,
  output logic [DW-1:0]        q_out,
  output logic [NUM_BYTES-1:0] drive
);
  // One independent lane per byte (R1)
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
    xcvr_lane #(.LANE_W(BYTE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_in   (d_in[k*BYTE_W +: BYTE_W]),
      .en_n   (en_n[k]),
      .hold_n (hold_n[k]),
      .drv_n  (drv_n[k]),
      .q_out  (q_out[k*BYTE_W +: BYTE_W]),
      .drive  (drive[k])
    );
  end
endmodule

// File: rtl/dual_bank_xcvr.sv
module dual_bank_xcvr #(
  parameter int NUM_BYTES = 2,
  parameter int BYTE_W    = 8,
  localparam int DW       = NUM_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        a_in,
  input  logic [DW-1:0]        b_in,
  input  logic [NUM_BYTES-1:0] ab_en_n,
  input  logic [NUM_BYTES-1:0] ab_hold_n,
  input  logic [NUM_BYTES-1:0] ab_drv_n,
  input  logic [NUM_BYTES-1:0] ba_en_n,
  input  logic [NUM_BYTES-1:0] ba_hold_n,
  input  logic [NUM_BYTES-1:0] ba_drv_n,
  output logic [DW-1:0]        b_out,
  output logic [NUM_BYTES-1:0] b_drive,
  output logic [DW-1:0]        a_out,
  output logic [NUM_BYTES-1:0] a_drive
);
  // A-to-B bank
  xcvr_dir #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_ab (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (a_in),
    .en_n   (ab_en_n),
    .hold_n (ab_hold_n),
    .drv_n  (ab_drv_n),
    .q_out  (b_out),
    .drive  (b_drive)
  );

  // B-to-A bank, separate storage (R7)
  xcvr_dir #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_ba (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (b_in),
    .en_n   (ba_en_n),
    .hold_n (ba_hold_n),
    .drv_n  (ba_drv_n),
    .q_out  (a_out),
    .drive  (a_drive)
  );

  AST_BA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    a_drive == (~ba_en_n & ~ba_drv_n)); // R7
  AST_AB_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    b_drive == (~ab_en_n & ~ab_drv_n)); // R2
endmodule

// File: tb/dual_bank_xcvr_tb.sv
module dual_bank_xcvr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a_in = '0, b_in = '0;
  logic [1:0]  ab_en_n = 2'b11, ab_hold_n = 2'b11, ab_drv_n = 2'b11;
  logic [1:0]  ba_en_n = 2'b11, ba_hold_n = 2'b11, ba_drv_n = 2'b11;
  logic [15:0] b_out, a_out;
  logic [1:0]  b_drive, a_drive;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_bank_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_en_n(ab_en_n), .ab_hold_n(ab_hold_n), .ab_drv_n(ab_drv_n),
    .ba_en_n(ba_en_n), .ba_hold_n(ba_hold_n), .ba_drv_n(ba_drv_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  // control packing: {en_n[1:0], hold_n[1:0], drv_n[1:0]}
  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [5:0]  ab;
    logic [5:0]  ba;
    logic [15:0] eb;
    logic [1:0]  ebd;
    logic [15:0] ea;
    logic [1:0]  ead;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{16'h1234, 16'hABCD, 6'b111100, 6'b111100, 16'h0000, 2'b00, 16'h0000, 2'b00}, // R2 enable high
    '{16'h1234, 16'hABCD, 6'b001100, 6'b111100, 16'h0000, 2'b11, 16'h0000, 2'b00}, // R8 cleared storage
    '{16'h1234, 16'hABCD, 6'b000000, 6'b111100, 16'h1234, 2'b11, 16'h0000, 2'b00}, // R4 open
    '{16'h5678, 16'hABCD, 6'b001100, 6'b111100, 16'h1234, 2'b11, 16'h0000, 2'b00}, // R5 held
    '{16'h9ABC, 16'hABCD, 6'b001000, 6'b111100, 16'h12BC, 2'b11, 16'h0000, 2'b00}, // R1 split hold
    '{16'h0000, 16'hABCD, 6'b010000, 6'b111100, 16'h0000, 2'b10, 16'h0000, 2'b00}, // R3 byte0 disabled
    '{16'hFFFF, 16'hABCD, 6'b001100, 6'b111100, 16'h00BC, 2'b11, 16'h0000, 2'b00}, // R6 byte0 kept
    '{16'hFFFF, 16'hC3A5, 6'b001111, 6'b000000, 16'h0000, 2'b00, 16'hC3A5, 2'b11}, // R7 reverse open
    '{16'hFFFF, 16'h0000, 6'b001100, 6'b001100, 16'h00BC, 2'b11, 16'hC3A5, 2'b11}, // R7 banks apart
    '{16'h7E81, 16'h0000, 6'b000011, 6'b110000, 16'h0000, 2'b00, 16'h0000, 2'b00}, // R3 load undriven
    '{16'h0000, 16'h0000, 6'b001100, 6'b111111, 16'h7E81, 2'b11, 16'h0000, 2'b00}, // R5 loaded w/o drive
    '{16'hFFFF, 16'h0000, 6'b110000, 6'b001101, 16'h0000, 2'b00, 16'hC300, 2'b10}, // R1 per-byte drive
    '{16'h0000, 16'h0000, 6'b001100, 6'b111111, 16'h7E81, 2'b11, 16'h0000, 2'b00}  // R6 enable blocks load
  };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act={b=%h bd=%b a=%h ad=%b} exp={b=%h bd=%b a=%h ad=%b}", req,
               act[35:20], act[19:18], act[17:2], act[1:0],
               exp[35:20], exp[19:18], exp[17:2], exp[1:0]);
    end
  endtask

  function automatic logic [35:0] outs();
    return {b_out, b_drive, a_out, a_drive};
  endfunction

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Reset state: held lanes driving show cleared storage (R8)
    ab_en_n = 2'b00; ab_hold_n = 2'b11; ab_drv_n = 2'b00;
    ba_en_n = 2'b00; ba_hold_n = 2'b11; ba_drv_n = 2'b00;
    repeat (2) @(negedge clk);
    #1 check("R8 reset", outs(), {16'h0000, 2'b11, 16'h0000, 2'b11});
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a_in = VEC[i].a; b_in = VEC[i].b;
      {ab_en_n, ab_hold_n, ab_drv_n} = VEC[i].ab;
      {ba_en_n, ba_hold_n, ba_drv_n} = VEC[i].ba;
      #1 check($sformatf("vector %0d", i), outs(),
               {VEC[i].eb, VEC[i].ebd, VEC[i].ea, VEC[i].ead});
    end

    // Mid-run reset clears both banks (R8)
    @(negedge clk);
    rst_n = 1'b0;
    ab_en_n = 2'b00; ab_hold_n = 2'b11; ab_drv_n = 2'b00;
    ba_en_n = 2'b00; ba_hold_n = 2'b11; ba_drv_n = 2'b00;
    #1 check("R8 mid-run reset", outs(), {16'h0000, 2'b11, 16'h0000, 2'b11});
    @(negedge clk); rst_n = 1'b1;

    // Complementary enables: never both directions on one byte (R2, R7)
    for (int i = 0; i < 64; i++) begin
      logic [1:0] ebd, ead;
      @(negedge clk);
      a_in = 16'hA5A5; b_in = 16'h5A5A;
      ab_hold_n = 2'b11; ba_hold_n = 2'b11;
      ab_en_n = i[1:0]; ba_en_n = ~i[1:0];
      ab_drv_n = i[3:2]; ba_drv_n = i[5:4];
      ebd = ~ab_en_n & ~ab_drv_n;
      ead = ~ba_en_n & ~ba_drv_n;
      #1 check($sformatf("R2 sweep %0d", i), outs(), {16'h0000, ebd, 16'h0000, ead});
      checks++;
      if ((b_drive & a_drive) != 2'b00) begin
        failures++;
        $display("FAIL R7 overlap act=%b exp=00", b_drive & a_drive);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule